// File: doc/BRIEF.md
# Synchronized Multi-Tap Output Divider

This block takes one fast clock and drives five outputs. Each output carries the clock itself or the clock divided by 2, 4, 8 or 16, picked by its own 3-bit code. All divided rates come from a single free-running 4-bit counter, and every output is retimed by one common register stage, so edges of different outputs line up. A separate 3-bit code picks one of the five retimed signals as the feedback clock for a phase comparator. The feedback is taken ahead of the per-output enable, so the loop keeps running while an output is switched off.

Each output has its own enable, and a power-down input switches every output off. A disabled output is held low and its enable flag drops. An active-low reset clears the counter and drives every output low. The selection inputs are plain ports, so their settings stay in force across the reset and apply again as soon as it is released.

Top module: `sync_tap_divider`

## Requirements
- R1: Output i takes its code from tapSel[3i+2:3i]. Code 0 gives the full-rate clock, code 1 divides by 2, code 2 by 4, code 3 by 8 and code 4 by 16. Each output's code is independent of the others.
- R2: Codes 5, 6 and 7 each give the divide-by-8 rate.
- R3: fbSel codes 0 to 4 route output 0 to 4 to fbOut, and codes 5 to 7 route output 3. fbOut follows the selected signal whatever that output's enable is.
- R4: The divided taps come from one counter. After reset is released, counting rising edges from k=1, a divide-by-2^j output (j=1..4) is high exactly when bit j-1 of (k-1) mod 16 is 0. So all divided outputs rise together on the first edge.
- R5: A full-rate output that is enabled is high while clk is high and low while clk is low.
- R6: A change of tapSel, fbSel, outEn or pwrDn takes effect at the next rising edge of clk and does not disturb the counter phase.
- R7: While rstN is low, yOut, yEn and fbOut are all low, starting at once and without waiting for a clock edge. The counter restarts from zero when rstN is released.
- R8: yEn[i] is high exactly when outEn[i] is high and pwrDn is low. When yEn[i] is low, yOut[i] stays low.
- R9: pwrDn high forces every yEn and yOut low. The counter and fbOut keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Active-low asynchronous reset of counter and outputs |
| tapSel | input | 15 | Rate code per output, 3 bits each, output 0 in bits 2:0 |
| fbSel | input | 3 | Feedback source code |
| outEn | input | 5 | Per-output enable |
| pwrDn | input | 1 | Forces all outputs off when high |
| yOut | output | 5 | Retimed output clocks |
| yEn | output | 5 | Per-output active flag |
| fbOut | output | 1 | Feedback clock to the phase comparator |

## Verification
The hardest case is a reset that lands in the middle of a run. It must silence even a full-rate output while the clock is high, and it must then restart every tap in phase. The bench first brings the counter to an arbitrary phase with a mix of codes, including code 0. It then drops rstN during the low phase and checks the outputs in the following high phase. After release it follows each divider through more than one full 16-edge period. Separate sweeps rotate all eight codes across all five outputs and the feedback select, and walk all 32 enable patterns, so that every code lands on every output position.

// File: rtl/stdiv_pkg.sv
package stdiv_pkg;
  localparam int NUM_OUT = 5;
  localparam int SEL_W   = 3;
  localparam int CNT_W   = 4;
  localparam int IDX_W   = 3;
  localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(CNT_W);
  localparam logic [IDX_W-1:0] FALLBACK  = IDX_W'(3);

  // tapIdx: 0 = full rate, j = divide by 2^j
  typedef struct packed {
    logic [NUM_OUT-1:0]       fullRate;
    logic [NUM_OUT-1:0]       drive;
    logic [NUM_OUT*IDX_W-1:0] tapIdx;
    logic [IDX_W-1:0]         fbIdx;
  } ctrl_strobe_t;

  function automatic logic [IDX_W-1:0] foldCode(input logic [SEL_W-1:0] code);
    return (code > LAST_CODE) ? FALLBACK : IDX_W'(code);
  endfunction
endpackage

// File: rtl/stdiv_ctrl.sv
module stdiv_ctrl
  import stdiv_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_OUT*SEL_W-1:0] tapSel,
  input  logic [SEL_W-1:0]         fbSel,
  input  logic [NUM_OUT-1:0]       outEn,
  input  logic                     pwrDn,
  output ctrl_strobe_t             strobe
);
  logic [NUM_OUT*IDX_W-1:0] idxNext;
  logic [NUM_OUT-1:0]       fullQ;
  logic [NUM_OUT-1:0]       driveQ;
  logic [IDX_W-1:0]         fbQ;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_decode
    assign idxNext[i*IDX_W +: IDX_W] = foldCode(tapSel[i*SEL_W +: SEL_W]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fullQ[i]  <= 1'b0;
        driveQ[i] <= 1'b0;
      end else begin
        fullQ[i]  <= (idxNext[i*IDX_W +: IDX_W] == '0);
        driveQ[i] <= outEn[i] & ~pwrDn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fbQ <= '0;
    else       fbQ <= foldCode(fbSel);
  end

  always_comb begin
    strobe.fullRate = fullQ;
    strobe.drive    = driveQ;
    strobe.tapIdx   = idxNext;
    strobe.fbIdx    = fbQ;
  end
endmodule

// File: rtl/stdiv_datapath.sv
module stdiv_datapath
  import stdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  output logic [NUM_OUT-1:0] yOut,
  output logic [NUM_OUT-1:0] yEn,
  output logic               fbOut
);
  logic [CNT_W-1:0]   phaseCnt;
  logic [NUM_OUT-1:0] tapQ;
  logic [NUM_OUT-1:0] rawTap;

  function automatic logic tapLevel(input logic [CNT_W-1:0] cnt,
                                    input logic [IDX_W-1:0] idx);
    logic lvl;
    lvl = 1'b0;
    for (int j = 1; j <= CNT_W; j++)
      if (idx == IDX_W'(j)) lvl = ~cnt[j-1];
    return lvl;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseCnt <= '0;
    else       phaseCnt <= phaseCnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tapQ[i] <= 1'b0;
      else       tapQ[i] <= tapLevel(phaseCnt, strobe.tapIdx[i*IDX_W +: IDX_W]);
    end
    assign rawTap[i] = strobe.fullRate[i] ? clk : tapQ[i];
    assign yOut[i]   = rawTap[i] & strobe.drive[i];
  end

  assign yEn = strobe.drive;

  always_comb begin
    fbOut = 1'b0;
    for (int i = 0; i < NUM_OUT; i++)
      if (strobe.fbIdx == IDX_W'(i)) fbOut = rawTap[i];
  end
endmodule

// File: rtl/sync_tap_divider.sv
module sync_tap_divider
  import stdiv_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_OUT*SEL_W-1:0] tapSel,
  input  logic [SEL_W-1:0]         fbSel,
  input  logic [NUM_OUT-1:0]       outEn,
  input  logic                     pwrDn,
  output logic [NUM_OUT-1:0]       yOut,
  output logic [NUM_OUT-1:0]       yEn,
  output logic                     fbOut
);
  ctrl_strobe_t strobe;

  stdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tapSel(tapSel), .fbSel(fbSel),
    .outEn(outEn), .pwrDn(pwrDn), .strobe(strobe)
  );

  stdiv_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .yOut(yOut), .yEn(yEn), .fbOut(fbOut)
  );
endmodule

// File: rtl/sync_tap_divider_chk.sv
module sync_tap_divider_chk
  import stdiv_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [SEL_W-1:0]   fbSel,
  input logic [NUM_OUT-1:0] outEn,
  input logic               pwrDn,
  input logic [NUM_OUT-1:0] yOut,
  input logic [NUM_OUT-1:0] yEn,
  input logic               fbOut
);
  logic [SEL_W-1:0]   fbPrev;
  logic [NUM_OUT-1:0] enPrev;
  logic               pdPrev;
  logic               runPrev;
  logic [IDX_W-1:0]   pick;
  logic               pickOn;
  logic               pickOut;

  always_ff @(posedge clk) begin
    fbPrev  <= fbSel;
    enPrev  <= outEn;
    pdPrev  <= pwrDn;
    runPrev <= rstN;
  end

  always_comb begin
    pick    = (fbPrev > 3'd4) ? 3'd3 : fbPrev;
    pickOn  = 1'b0;
    pickOut = 1'b0;
    for (int i = 0; i < NUM_OUT; i++)
      if (pick == IDX_W'(i)) begin
        pickOn  = enPrev[i] & ~pdPrev;
        pickOut = yOut[i];
      end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (yOut == '0 && yEn == '0 && !fbOut)); // R7
  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (yOut & ~yEn) == '0); // R8
  AST_PD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (runPrev && pdPrev) |-> yEn == '0); // R9
  AST_EN_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    runPrev |-> yEn == (enPrev & {NUM_OUT{~pdPrev}})); // R6
  AST_FB_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (runPrev && pickOn) |-> fbOut == pickOut); // R3
endmodule

bind sync_tap_divider sync_tap_divider_chk u_chk (
  .clk(clk), .rstN(rstN), .fbSel(fbSel), .outEn(outEn), .pwrDn(pwrDn),
  .yOut(yOut), .yEn(yEn), .fbOut(fbOut)
);

// File: tb/tb_sync_tap_divider.sv
module tb_sync_tap_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT = 5;

  logic          clk = 1'b0;
  logic          rstN;
  logic [14:0]   tapSel;
  logic [2:0]    fbSel;
  logic [4:0]    outEn;
  logic          pwrDn;
  logic [4:0]    yOut;
  logic [4:0]    yEn;
  logic          fbOut;

  int checks = 0;
  int errors = 0;
  int edgeK  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tap_divider dut (
    .clk(clk), .rstN(rstN), .tapSel(tapSel), .fbSel(fbSel),
    .outEn(outEn), .pwrDn(pwrDn), .yOut(yOut), .yEn(yEn), .fbOut(fbOut)
  );

  // expected level of a tap with the given code after edge k
  function automatic logic expTap(int code, int k, bit hi);
    int c;
    if (k == 0) return 1'b0;
    c = (code > 4) ? 3 : code;
    if (c == 0) return hi;
    return ((((k - 1) % 16) >> (c - 1)) & 1) == 0;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b time=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string req, bit hi);
    int pick;
    logic e;
    for (int i = 0; i < NOUT; i++) begin
      e = (rstN && outEn[i] && !pwrDn) ? expTap(int'(tapSel[i*3 +: 3]), edgeK, hi) : 1'b0;
      chk(req, $sformatf("yOut[%0d]", i), yOut[i], e);
      chk(req, $sformatf("yEn[%0d]", i), yEn[i], rstN && outEn[i] && !pwrDn);
    end
    pick = (fbSel > 4) ? 3 : int'(fbSel);
    chk(req, "fbOut", fbOut, rstN ? expTap(int'(tapSel[pick*3 +: 3]), edgeK, hi) : 1'b0);
  endtask

  task automatic cycle(string req);
    @(posedge clk);
    if (rstN) edgeK++;
    #2 checkAll(req, 1'b1);
    #5 checkAll(req, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN   = 1'b0;
    tapSel = {3'd0, 3'd4, 3'd3, 3'd2, 3'd1};
    fbSel  = 3'd0;
    outEn  = 5'h1F;
    pwrDn  = 1'b0;
    repeat (3) @(posedge clk);
    #7 checkAll("R7", 1'b0);
    edgeK = 0;
    rstN  = 1'b1;
    // R4: first edge all divided taps high, then full period phase
    repeat (34) cycle("R4");

    // R1 R2 R3 R6: rotate every code over every output and feedback
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < NOUT; i++) tapSel[i*3 +: 3] = 3'((p + i) % 8);
      fbSel = 3'(p);
      repeat (18) cycle((p < 5) ? "R1 R3 R6" : "R2 R3 R6");
    end

    // R8: every enable pattern
    tapSel = {3'd7, 3'd0, 3'd2, 3'd1, 3'd4};
    for (int m = 0; m < 32; m++) begin
      outEn = 5'(m);
      fbSel = 3'(m % 8);
      repeat (3) cycle("R8 R3");
    end

    // R9: power-down, feedback keeps running
    outEn = 5'h1F;
    pwrDn = 1'b1;
    repeat (20) cycle("R9");
    pwrDn = 1'b0;
    repeat (3) cycle("R9 R6");

    // R5: full rate on every output
    tapSel = '0;
    repeat (5) cycle("R5");

    // R7: reset mid-run with mixed codes
    tapSel = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4};
    fbSel  = 3'd4;
    repeat (5) cycle("R7");
    rstN = 1'b0;
    #1 checkAll("R7", 1'b0);
    @(posedge clk);
    #2 checkAll("R7", 1'b1);
    #5 checkAll("R7", 1'b0);
    edgeK = 0;
    rstN  = 1'b1;
    repeat (34) cycle("R4 R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule